// File: doc/BRIEF.md
# Register window pointer and status word controller

This block keeps the current window pointer and the window invalid mask for a processor whose register file is split into a parameterised number of overlapping windows. The count can be set from 2 to 32. The block also holds the fields of the processor status word: condition codes, floating-point enable, interrupt level, supervisor, previous supervisor and trap enable. It presents all of them as one 32-bit word.

The decoder sends one-cycle command pulses: window advance (save), window retreat (restore), return from trap, and status-word write. For each command the block works out the next pointer with wrap-around and tests the invalid mask at that index. It then either commits the new state or raises a one-cycle trap with a code. The invalid mask has its own write port. Trap vectoring, the register file and interrupt arbitration are left to the surrounding core.

Top module: `regwin_ctrl`

## Requirements
- R1: Reset makes the pointer 0, the mask 0, supervisor 1 and every other status field 0. The status word then reads `{VERSION, 24'h000080}`, and no trap is shown.
- R2: A save moves the pointer down by one, wrapping from 0 to NWIN-1. If the mask bit at the new index is set, it raises overflow (code 2'b01) instead and the pointer keeps its value.
- R3: A restore moves the pointer up by one, wrapping from NWIN-1 to 0. If the mask bit at the new index is set, it raises underflow (code 2'b10) instead and the pointer keeps its value.
- R4: A return from trap issued while trap enable is 1 raises illegal instruction (code 2'b11) and changes no status field.
- R5: A return from trap issued while trap enable is 0 always sets trap enable. If the mask bit at pointer+1 (with wrap) is set, it raises underflow and keeps the pointer and supervisor. Otherwise it commits the pointer and copies previous supervisor into supervisor.
- R6: A status write whose pointer field (bits 4:0) is NWIN or more raises illegal instruction and leaves the word unchanged. Any value up to NWIN-1 is accepted.
- R7: Status word layout: bits 31:24 are the constant VERSION and cannot be written, bits 23:20 are the condition codes, bit 12 is FP enable, bits 11:8 are the interrupt level, bit 7 is supervisor, bit 6 is previous supervisor, bit 5 is trap enable and bits 4:0 are the pointer. Bits 19:13 read 0.
- R8: When several command pulses share a cycle, only one is acted on, in this order: status write, then return from trap, then save, then restore.
- R9: The trap flag is high for exactly the one cycle after the command edge that raised it. The code reads 2'b00 whenever the flag is low.
- R10: A mask write shows on the mask output after the edge. A command in the same cycle tests the mask value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| save_i | input | 1 | Save command pulse |
| restore_i | input | 1 | Restore command pulse |
| rett_i | input | 1 | Return-from-trap command pulse |
| sr_wr_i | input | 1 | Status-word write pulse |
| sr_wdata_i | input | 32 | Status word to write |
| mask_we_i | input | 1 | Invalid-mask write enable |
| mask_wdata_i | input | NWIN | New invalid mask |
| sr_o | output | 32 | Packed status word |
| cwp_o | output | 5 | Current window pointer |
| mask_o | output | NWIN | Current invalid mask |
| trap_o | output | 1 | Trap raised by the previous command |
| trap_code_o | output | 2 | Trap code: 01 overflow, 10 underflow, 11 illegal |

## Verification
A mask write and a save or restore can land in the same cycle. The window test must then use the old mask while the new mask is stored. The bench provokes this by clearing a bit and setting a different one with the same write, in the same cycle as a save that points at the newly set bit. It expects the save to commit and the new mask to block the next window move. Command collisions are handled the same way: several pulses are raised together, and the bench expects the resulting word to show only the effect of the highest-priority command.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    typedef enum logic [1:0] {
        TRAP_NONE  = 2'b00,
        TRAP_OVF   = 2'b01,
        TRAP_UNF   = 2'b10,
        TRAP_ILL   = 2'b11
    } trap_code_e;

    // Status fields other than the window pointer
    typedef struct packed {
        logic [3:0] icc;
        logic       ef;
        logic [3:0] pil;
        logic       s;
        logic       ps;
        logic       et;
    } sr_fields_t;

    localparam int SR_CWP_W = 5;

endpackage

// File: rtl/regwin_step.sv
module regwin_step #(
    parameter int NWIN = 8,
    localparam int CW  = $clog2(NWIN)
) (
    input  logic [CW-1:0] cur_i,
    output logic [CW-1:0] up_o,
    output logic [CW-1:0] dn_o
);
    localparam logic [CW-1:0] TOP = CW'(NWIN - 1);

    always_comb begin
        up_o = (cur_i == TOP)   ? '0  : cur_i + 1'b1;
        dn_o = (cur_i == '0)    ? TOP : cur_i - 1'b1;
    end
endmodule

// File: rtl/regwin_sr_codec.sv
module regwin_sr_codec
    import regwin_pkg::*;
#(
    parameter int          NWIN    = 8,
    parameter logic [7:0]  VERSION = 8'hA3,
    localparam int         CW      = $clog2(NWIN)
) (
    input  sr_fields_t      f_i,
    input  logic [CW-1:0]   cwp_i,
    output logic [31:0]     word_o,
    input  logic [31:0]     wdata_i,
    output sr_fields_t      f_o,
    output logic [4:0]      cwp_o
);
    always_comb begin
        word_o = {VERSION, f_i.icc, 7'b0, f_i.ef, f_i.pil,
                  f_i.s, f_i.ps, f_i.et, SR_CWP_W'(cwp_i)};
        f_o.icc = wdata_i[23:20];
        f_o.ef  = wdata_i[12];
        f_o.pil = wdata_i[11:8];
        f_o.s   = wdata_i[7];
        f_o.ps  = wdata_i[6];
        f_o.et  = wdata_i[5];
        cwp_o   = wdata_i[4:0];
    end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
    import regwin_pkg::*;
#(
    parameter int         NWIN    = 8,
    parameter logic [7:0] VERSION = 8'hA3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save_i,
    input  logic            restore_i,
    input  logic            rett_i,
    input  logic            sr_wr_i,
    input  logic [31:0]     sr_wdata_i,
    input  logic            mask_we_i,
    input  logic [NWIN-1:0] mask_wdata_i,
    output logic [31:0]     sr_o,
    output logic [4:0]      cwp_o,
    output logic [NWIN-1:0] mask_o,
    output logic            trap_o,
    output logic [1:0]      trap_code_o
);
    localparam int       CW     = $clog2(NWIN);
    localparam logic [5:0] NWIN6 = 6'(NWIN);

    typedef struct packed {
        logic [CW-1:0]   cwp;
        logic [NWIN-1:0] mask;
        sr_fields_t      f;
        logic            trap;
        trap_code_e      code;
    } state_t;

    state_t     st_q, st_d;
    logic [CW-1:0] cwp_up, cwp_dn;
    sr_fields_t wr_f;
    logic [4:0] wr_cwp;
    logic       wr_ok;

    regwin_step #(.NWIN(NWIN)) u_step (
        .cur_i (st_q.cwp),
        .up_o  (cwp_up),
        .dn_o  (cwp_dn)
    );

    regwin_sr_codec #(.NWIN(NWIN), .VERSION(VERSION)) u_codec (
        .f_i     (st_q.f),
        .cwp_i   (st_q.cwp),
        .word_o  (sr_o),
        .wdata_i (sr_wdata_i),
        .f_o     (wr_f),
        .cwp_o   (wr_cwp)
    );

    assign wr_ok = ({1'b0, wr_cwp} < NWIN6);

    always_comb begin
        st_d      = st_q;
        st_d.trap = 1'b0;
        st_d.code = TRAP_NONE;
        if (mask_we_i) st_d.mask = mask_wdata_i;

        if (sr_wr_i) begin
            if (!wr_ok) begin
                st_d.trap = 1'b1;
                st_d.code = TRAP_ILL;
            end else begin
                st_d.f   = wr_f;
                st_d.cwp = wr_cwp[CW-1:0];
            end
        end else if (rett_i) begin
            if (st_q.f.et) begin
                st_d.trap = 1'b1;
                st_d.code = TRAP_ILL;
            end else begin
                st_d.f.et = 1'b1;
                if (st_q.mask[cwp_up]) begin
                    st_d.trap = 1'b1;
                    st_d.code = TRAP_UNF;
                end else begin
                    st_d.cwp  = cwp_up;
                    st_d.f.s  = st_q.f.ps;
                end
            end
        end else if (save_i) begin
            if (st_q.mask[cwp_dn]) begin
                st_d.trap = 1'b1;
                st_d.code = TRAP_OVF;
            end else begin
                st_d.cwp = cwp_dn;
            end
        end else if (restore_i) begin
            if (st_q.mask[cwp_up]) begin
                st_d.trap = 1'b1;
                st_d.code = TRAP_UNF;
            end else begin
                st_d.cwp = cwp_up;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.f.s  <= 1'b1;
            st_q.code <= TRAP_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign cwp_o       = 5'(st_q.cwp);
    assign mask_o      = st_q.mask;
    assign trap_o      = st_q.trap;
    assign trap_code_o = st_q.code;
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
    parameter int NWIN = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        save_i,
    input logic        restore_i,
    input logic        rett_i,
    input logic        sr_wr_i,
    input logic [31:0] sr_o,
    input logic [4:0]  cwp_o,
    input logic        trap_o,
    input logic [1:0]  trap_code_o
);
    logic any_cmd;
    assign any_cmd = save_i | restore_i | rett_i | sr_wr_i;

    AST_CWP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cwp_o) < NWIN); // R6

    AST_OVF_KEEPS_CWP: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && trap_code_o == 2'b01) |-> cwp_o == $past(cwp_o)); // R2

    AST_UNF_KEEPS_CWP: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && trap_code_o == 2'b10) |-> cwp_o == $past(cwp_o)); // R3

    AST_ILL_FREEZES_SR: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && trap_code_o == 2'b11) |-> sr_o == $past(sr_o)); // R4

    AST_RETT_SETS_ET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rett_i && !sr_wr_i) |-> sr_o[5]); // R5

    AST_TRAP_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> $past(any_cmd)); // R9

    AST_CODE_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_o |-> trap_code_o == 2'b00); // R9

    AST_IDLE_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(any_cmd) |-> $stable(sr_o)); // R8
endmodule

bind regwin_ctrl regwin_chk #(.NWIN(NWIN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .save_i      (save_i),
    .restore_i   (restore_i),
    .rett_i      (rett_i),
    .sr_wr_i     (sr_wr_i),
    .sr_o        (sr_o),
    .cwp_o       (cwp_o),
    .trap_o      (trap_o),
    .trap_code_o (trap_code_o)
);

// File: tb/tb_regwin_ctrl.sv
`timescale 1ns/1ps
module tb_regwin_ctrl;
    localparam int NWIN = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            save_i = 1'b0, restore_i = 1'b0, rett_i = 1'b0, sr_wr_i = 1'b0;
    logic [31:0]     sr_wdata_i = '0;
    logic            mask_we_i = 1'b0;
    logic [NWIN-1:0] mask_wdata_i = '0;
    logic [31:0]     sr_o;
    logic [4:0]      cwp_o;
    logic [NWIN-1:0] mask_o;
    logic            trap_o;
    logic [1:0]      trap_code_o;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk; // 250 MHz

    regwin_ctrl #(.NWIN(NWIN), .VERSION(8'hA3)) dut (.*);

    // cmd = {sr_wr, rett, save, restore}
    typedef struct packed {
        logic [3:0]  cmd;
        logic        mwe;
        logic [7:0]  mask;
        logic [31:0] data;
        logic [31:0] eword;
        logic [1:0]  etrap;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{4'b0010, 1'b0, 8'h00, 32'h0, 32'hA3000087, 2'b00, 4'd2},  // R2 wrap 0->7
        '{4'b0010, 1'b0, 8'h00, 32'h0, 32'hA3000086, 2'b00, 4'd2},  // R2
        '{4'b0001, 1'b0, 8'h00, 32'h0, 32'hA3000087, 2'b00, 4'd3},  // R3
        '{4'b0001, 1'b0, 8'h00, 32'h0, 32'hA3000080, 2'b00, 4'd3},  // R3 wrap 7->0
        '{4'b0000, 1'b1, 8'h02, 32'h0, 32'hA3000080, 2'b00, 4'd10}, // R10
        '{4'b0001, 1'b0, 8'h00, 32'h0, 32'hA3000080, 2'b10, 4'd3},  // R3 underflow
        '{4'b0010, 1'b1, 8'h80, 32'h0, 32'hA3000087, 2'b00, 4'd10}, // R10 old mask used
        '{4'b0001, 1'b0, 8'h00, 32'h0, 32'hA3000080, 2'b00, 4'd3},  // R3
        '{4'b0010, 1'b0, 8'h00, 32'h0, 32'hA3000080, 2'b01, 4'd2},  // R2 overflow
        '{4'b1000, 1'b0, 8'h00, 32'hFFF00F25, 32'hA3F00F25, 2'b00, 4'd7}, // R7
        '{4'b0100, 1'b0, 8'h00, 32'h0, 32'hA3F00F25, 2'b11, 4'd4},  // R4
        '{4'b1000, 1'b0, 8'h00, 32'h00001048, 32'hA3F00F25, 2'b11, 4'd6}, // R6
        '{4'b1000, 1'b0, 8'h00, 32'h00001046, 32'hA3001046, 2'b00, 4'd7}, // R7
        '{4'b0100, 1'b0, 8'h00, 32'h0, 32'hA3001066, 2'b10, 4'd5},  // R5 underflow sets ET
        '{4'b1000, 1'b0, 8'h00, 32'h00001047, 32'hA3001047, 2'b00, 4'd7}, // R7
        '{4'b0000, 1'b1, 8'h00, 32'h0, 32'hA3001047, 2'b00, 4'd10}, // R10
        '{4'b0100, 1'b0, 8'h00, 32'h0, 32'hA30010E0, 2'b00, 4'd5},  // R5 commit, S<=PS
        '{4'b1011, 1'b0, 8'h00, 32'h00000003, 32'hA3000003, 2'b00, 4'd8}, // R8
        '{4'b0110, 1'b0, 8'h00, 32'h0, 32'hA3000024, 2'b00, 4'd8},  // R8 rett over save
        '{4'b0011, 1'b0, 8'h00, 32'h0, 32'hA3000023, 2'b00, 4'd8},  // R8 save over restore
        '{4'b1100, 1'b0, 8'h00, 32'h0000001F, 32'hA3000023, 2'b11, 4'd8}, // R8 R6
        '{4'b0000, 1'b0, 8'h00, 32'h0, 32'hA3000023, 2'b00, 4'd9}   // R9 trap gone
    };

    task automatic check(input logic [31:0] ew, input logic [1:0] et,
                         input logic [NWIN-1:0] em, input logic use_m, input int rq);
        n_chk++;
        if (sr_o !== ew || cwp_o !== ew[4:0] || trap_o !== (et != 2'b00) ||
            trap_code_o !== et || (use_m && mask_o !== em)) begin
            n_bad++;
            $display("FAIL R%0d: word=%h cwp=%0d trap=%b code=%b mask=%h, expected word=%h cwp=%0d code=%b mask=%h",
                     rq, sr_o, cwp_o, trap_o, trap_code_o, mask_o, ew, ew[4:0], et, em);
        end
    endtask

    task automatic apply(input logic [3:0] cmd, input logic mwe,
                         input logic [7:0] m, input logic [31:0] d);
        @(negedge clk);
        {sr_wr_i, rett_i, save_i, restore_i} = cmd;
        mask_we_i    = mwe;
        mask_wdata_i = m;
        sr_wdata_i   = d;
        @(negedge clk);
        {sr_wr_i, rett_i, save_i, restore_i} = 4'b0;
        mask_we_i = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        check(32'hA3000080, 2'b00, '0, 1'b1, 1); // R1 during reset
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(32'hA3000080, 2'b00, '0, 1'b1, 1); // R1 after release

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].cmd, VEC[i].mwe, VEC[i].mask, VEC[i].data);
            check(VEC[i].eword, VEC[i].etrap, '0, 1'b0, int'(VEC[i].req));
        end

        // R10: mask write is visible on the output
        apply(4'b0000, 1'b1, 8'h5A, 32'h0);
        check(32'hA3000023, 2'b00, 8'h5A, 1'b1, 10);
        // R6: pointer field of NWIN-1 is accepted
        apply(4'b1000, 1'b0, 8'h00, 32'h00000007);
        check(32'hA3000007, 2'b00, 8'h5A, 1'b1, 6);
        // R2: save from 7 to 6 blocked by mask bit 6 (0x5A)
        apply(4'b0010, 1'b0, 8'h00, 32'h0);
        check(32'hA3000007, 2'b01, 8'h5A, 1'b1, 2);
        // R1: reset in mid-run restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(32'hA3000080, 2'b00, '0, 1'b1, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(32'hA3000080, 2'b00, '0, 1'b1, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule